// File: doc/BRIEF.md
# SPI Master Controller with Threshold-Interrupt FIFOs

This block is a register-mapped SPI master. Software fills a 32-entry transmit queue through a 32-bit register port, and each queued byte is shifted out on `mosi`, most significant bit first. The byte sampled on `miso` during the same eight clocks is stored in a 32-entry receive queue, which software drains through the same port. All four combinations of clock polarity and phase are supported. The serial clock runs at the module clock divided by an even divider. Two active-low device selects are driven straight from a select register. A single interrupt line is the OR of five masked interrupt sources.

The interrupt sources work as follows. Two of them follow queue occupancy: receive-full compares the receive level with a programmed threshold, and transmit-empty compares the transmit level with another threshold. The other three are sticky error flags for transmit overflow, receive overflow and receive underflow. Each flag is cleared selectively by writing ones to a clear register. A busy status bit tells software when the last queued frame has fully left the shifter.

The shifter is a five-state machine:
- `ST_IDLE` waits for an enabled controller with a non-empty transmit queue, then goes to `ST_LOAD`.
- `ST_LOAD` pops one byte into the shift register and goes to `ST_HALF_A`.
- `ST_HALF_A` holds the first half of a bit period. When its half-period count expires it samples `miso` and moves to `ST_HALF_B`.
- `ST_HALF_B` holds the second half. On expiry it either advances to the next bit (back to `ST_HALF_A`) or, after the eighth bit, goes to `ST_FINISH`.
- `ST_FINISH` pushes the received byte and returns to `ST_IDLE`.
- Clearing the enable forces `ST_IDLE` from any state.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset: status reads 0x0C, both level registers read 0, `cs_n` is 2'b11, `irq` is 0, `sclk` is 0 and the raw interrupt register (0x2C) reads 0x01.
- R2: Frames are full duplex. A byte written to TXDATA (0x40) appears on `mosi` MSB first. The eight bits sampled on `miso` are read back from RXDATA (0x44) in arrival order, including back-to-back frames.
- R3: CTRL (0x00) bit 7 sets the idle level of `sclk`. CTRL bit 6 picks the sampling edge: the first edge of a bit when the bit is 0, the second edge when it is 1.
- R4: Each `sclk` half period lasts E/2 module clocks. E is DIV (0x0C) with bit 0 cleared, and is raised to 2 if the result is below 2.
- R5: CSEL (0x08) bit 0 drives `cs_n[0]` low and bit 1 drives `cs_n[1]` low. A select stays low across back-to-back frames for as long as its bit is set, and writing 0 releases both.
- R6: ENABLE (0x04) bit 0 runs the controller. While it is 0, the shifter stops, both queues are emptied, and TXDATA writes are discarded without raising any flag.
- R7: A TXDATA write to a full (32-entry) transmit queue is dropped and sets raw bit 1 (transmit overflow).
- R8: An RXDATA read of an empty receive queue returns 0 and sets raw bit 2 (receive underflow).
- R9: A received byte that arrives while the receive queue holds 32 entries is dropped and sets raw bit 3 (receive overflow).
- R10: A write to ICLR (0x30) clears sticky flags per bit: bit 3 clears transmit overflow, bit 2 clears receive overflow, bit 1 clears receive underflow, and bit 0 clears all three.
- R11: Raw bit 4 is high when the receive level is at least RXTHR (0x14) + 1. Raw bit 0 is high when the transmit level is at most TXTHR (0x10).
- R12: ISTAT (0x28) is the raw register ANDed with IMASK (0x24), and `irq` is the OR of ISTAT.
- R13: The STATUS (0x20) bits are: bit 4 receive full, bit 3 receive empty, bit 2 transmit empty, bit 1 transmit full, bit 0 busy. Busy is high while a frame is in the shifter or the transmit queue holds data.
- R14: TXLVL (0x18) and RXLVL (0x1C) report queue occupancy from 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of RXDATA pops the queue |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low device selects |
| irq | output | 1 | Interrupt request |

## Verification
A slave model on the bench samples `mosi` on the edge that the programmed mode calls for, and returns a different reply byte in every frame. Single frames are sent in each of the four modes, with tx bytes that put a lone 1 or a lone 0 at either end. A mismatch in bit order, sampling edge or idle level therefore shows up as a wrong byte on one side or the other.

Divider values that are odd, zero and even are applied, and the measured half period separates the even-forcing rule from the minimum-of-2 rule. Bursts of 4, 33 and 40 bytes exercise the following:
- back-to-back frames with the select held low;
- both threshold comparisons, just below and at their trip points;
- all three sticky flags;
- the per-bit clear, where clearing the wrong bit must leave a flag set.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HALF_A,
        ST_HALF_B,
        ST_FINISH
    } shift_state_t;

    localparam int FRAME_BITS = 8;
    localparam int IRQ_W      = 5;

    // interrupt source positions
    localparam int IRQ_TXE  = 0;
    localparam int IRQ_TXOV = 1;
    localparam int IRQ_RXUN = 2;
    localparam int IRQ_RXOV = 3;
    localparam int IRQ_RXF  = 4;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_ENABLE = 8'h04;
    localparam logic [7:0] OFS_CSEL   = 8'h08;
    localparam logic [7:0] OFS_DIV    = 8'h0C;
    localparam logic [7:0] OFS_TXTHR  = 8'h10;
    localparam logic [7:0] OFS_RXTHR  = 8'h14;
    localparam logic [7:0] OFS_TXLVL  = 8'h18;
    localparam logic [7:0] OFS_RXLVL  = 8'h1C;
    localparam logic [7:0] OFS_STATUS = 8'h20;
    localparam logic [7:0] OFS_IMASK  = 8'h24;
    localparam logic [7:0] OFS_ISTAT  = 8'h28;
    localparam logic [7:0] OFS_IRAW   = 8'h2C;
    localparam logic [7:0] OFS_ICLR   = 8'h30;
    localparam logic [7:0] OFS_TXDATA = 8'h40;
    localparam logic [7:0] OFS_RXDATA = 8'h44;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [LW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];
    assign level   = count;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cpol,
    input  logic               cpha,
    input  logic [DIV_W-1:0]   div,
    input  logic               tx_ready,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               miso,
    output logic               tx_take,
    output logic               rx_put,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sclk,
    output logic               mosi,
    output logic               running,
    output shift_state_t       state_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam int HW    = DIV_W - 1;

    shift_state_t       state;
    shift_state_t       state_nx;
    logic [HW-1:0]      hcnt;
    logic [HW-1:0]      half;
    logic [DIV_W-1:0]   even_div;
    logic               half_done;
    logic [CNT_W-1:0]   bit_cnt;
    logic               last_bit;
    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;

    assign even_div  = {div[DIV_W-1:1], 1'b0};
    assign half      = (even_div < DIV_W'(2)) ? HW'(1) : even_div[DIV_W-1:1];
    assign half_done = (hcnt == half - HW'(1));
    assign last_bit  = (bit_cnt == CNT_W'(FRAME_W-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (tx_ready) state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_HALF_A;
            ST_HALF_A: if (half_done) state_nx = ST_HALF_B;
            ST_HALF_B: if (half_done) state_nx = last_bit ? ST_FINISH : ST_HALF_A;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (!enable) state_nx = ST_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt    <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    tx_sh   <= tx_data;
                    hcnt    <= '0;
                    bit_cnt <= '0;
                end
                ST_HALF_A: begin
                    if (half_done) begin
                        hcnt  <= '0;
                        rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_HALF_B: begin
                    if (half_done) begin
                        hcnt <= '0;
                        if (!last_bit) begin
                            tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: hcnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_take = enable && (state == ST_LOAD);
        rx_put  = enable && (state == ST_FINISH);
        rx_data = rx_sh;
        mosi    = tx_sh[FRAME_W-1];
        running = (state != ST_IDLE);
        state_o = state;
        unique case (state)
            ST_HALF_A: sclk = cpol ^ cpha;
            ST_HALF_B: sclk = ~(cpol ^ cpha);
            default:   sclk = cpol;
        endcase
    end

endmodule

// File: rtl/spim_irq.sv
module spim_irq
    import spim_pkg::*;
#(
    parameter int THR_W = 5,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [IRQ_W-1:0] mask,
    input  logic             set_txov,
    input  logic             set_rxov,
    input  logic             set_rxun,
    input  logic             clr_wr,
    input  logic [3:0]       clr_bits,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic txov_q;
    logic rxov_q;
    logic rxun_q;
    logic clr_all;

    assign clr_all = clr_wr && clr_bits[0];

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txov_q <= 1'b0;
            rxov_q <= 1'b0;
            rxun_q <= 1'b0;
        end else begin
            txov_q <= set_txov || (txov_q && !(clr_all || (clr_wr && clr_bits[3])));
            rxov_q <= set_rxov || (rxov_q && !(clr_all || (clr_wr && clr_bits[2])));
            rxun_q <= set_rxun || (rxun_q && !(clr_all || (clr_wr && clr_bits[1])));
        end
    end

    always_comb begin
        raw           = '0;
        raw[IRQ_RXF]  = (rx_level > LVL_W'(rx_thr));
        raw[IRQ_RXOV] = rxov_q;
        raw[IRQ_RXUN] = rxun_q;
        raw[IRQ_TXOV] = txov_q;
        raw[IRQ_TXE]  = (tx_level <= LVL_W'(tx_thr));
        masked        = raw & mask;
        irq           = |masked;
    end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int DIV_W      = 16,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CS_N       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_N-1:0]   cs_n,
    output logic              irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);
    localparam int THR_W = $clog2(FIFO_DEPTH);

    // configuration state
    logic                  cpol_q;
    logic                  cpha_q;
    logic                  en_q;
    logic [CS_N-1:0]       csel_q;
    logic [DIV_W-1:0]      div_q;
    logic [THR_W-1:0]      txthr_q;
    logic [THR_W-1:0]      rxthr_q;
    logic [IRQ_W-1:0]      imask_q;

    // queue and shifter wiring
    logic [FRAME_BITS-1:0] tx_head;
    logic [FRAME_BITS-1:0] rx_head;
    logic [FRAME_BITS-1:0] rx_byte;
    logic                  tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0]      tx_level, rx_level;
    logic                  tx_take, rx_put;
    logic                  sh_running;
    shift_state_t          sh_state;
    logic                  busy_w;
    logic [IRQ_W-1:0]      irq_raw, irq_masked;

    // access decode
    logic wr_txdata, rd_rxdata, wr_iclr;
    logic tx_ov_evt, rx_ov_evt, rx_under_evt, rx_take;

    function automatic logic hit(input logic [7:0] ofs);
        return bus_addr == ADDR_W'(ofs);
    endfunction

    assign wr_txdata    = bus_wr && hit(OFS_TXDATA);
    assign rd_rxdata    = bus_rd && hit(OFS_RXDATA);
    assign wr_iclr      = bus_wr && hit(OFS_ICLR);
    assign tx_ov_evt    = wr_txdata && en_q && tx_full;
    assign rx_ov_evt    = rx_put && rx_full;
    assign rx_under_evt = rd_rxdata && rx_empty;
    assign rx_take      = rd_rxdata && !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            en_q    <= 1'b0;
            csel_q  <= '0;
            div_q   <= '0;
            txthr_q <= '0;
            rxthr_q <= '0;
            imask_q <= '0;
        end else if (bus_wr) begin
            if (hit(OFS_CTRL)) begin
                cpol_q <= bus_wdata[7];
                cpha_q <= bus_wdata[6];
            end
            if (hit(OFS_ENABLE)) en_q    <= bus_wdata[0];
            if (hit(OFS_CSEL))   csel_q  <= bus_wdata[CS_N-1:0];
            if (hit(OFS_DIV))    div_q   <= bus_wdata[DIV_W-1:0];
            if (hit(OFS_TXTHR))  txthr_q <= bus_wdata[THR_W-1:0];
            if (hit(OFS_RXTHR))  rxthr_q <= bus_wdata[THR_W-1:0];
            if (hit(OFS_IMASK))  imask_q <= bus_wdata[IRQ_W-1:0];
        end
    end

    spim_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!en_q),
        .push      (wr_txdata && en_q),
        .push_data (bus_wdata[FRAME_BITS-1:0]),
        .pop       (tx_take),
        .head      (tx_head),
        .full      (tx_full),
        .empty     (tx_empty),
        .level     (tx_level)
    );

    spim_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!en_q),
        .push      (rx_put),
        .push_data (rx_byte),
        .pop       (rx_take),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty),
        .level     (rx_level)
    );

    spim_shifter #(.DIV_W(DIV_W), .FRAME_W(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (en_q),
        .cpol     (cpol_q),
        .cpha     (cpha_q),
        .div      (div_q),
        .tx_ready (!tx_empty),
        .tx_data  (tx_head),
        .miso     (miso),
        .tx_take  (tx_take),
        .rx_put   (rx_put),
        .rx_data  (rx_byte),
        .sclk     (sclk),
        .mosi     (mosi),
        .running  (sh_running),
        .state_o  (sh_state)
    );

    spim_irq #(.THR_W(THR_W), .LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (txthr_q),
        .rx_thr   (rxthr_q),
        .mask     (imask_q),
        .set_txov (tx_ov_evt),
        .set_rxov (rx_ov_evt),
        .set_rxun (rx_under_evt),
        .clr_wr   (wr_iclr),
        .clr_bits (bus_wdata[3:0]),
        .raw      (irq_raw),
        .masked   (irq_masked),
        .irq      (irq)
    );

    assign busy_w = sh_running || !tx_empty;
    assign cs_n   = ~csel_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   bus_rdata = DATA_W'({cpol_q, cpha_q, 6'b0});
            ADDR_W'(OFS_ENABLE): bus_rdata = DATA_W'(en_q);
            ADDR_W'(OFS_CSEL):   bus_rdata = DATA_W'(csel_q);
            ADDR_W'(OFS_DIV):    bus_rdata = DATA_W'(div_q);
            ADDR_W'(OFS_TXTHR):  bus_rdata = DATA_W'(txthr_q);
            ADDR_W'(OFS_RXTHR):  bus_rdata = DATA_W'(rxthr_q);
            ADDR_W'(OFS_TXLVL):  bus_rdata = DATA_W'(tx_level);
            ADDR_W'(OFS_RXLVL):  bus_rdata = DATA_W'(rx_level);
            ADDR_W'(OFS_STATUS): bus_rdata = DATA_W'({rx_full, rx_empty, tx_empty, tx_full, busy_w});
            ADDR_W'(OFS_IMASK):  bus_rdata = DATA_W'(imask_q);
            ADDR_W'(OFS_ISTAT):  bus_rdata = DATA_W'(irq_masked);
            ADDR_W'(OFS_IRAW):   bus_rdata = DATA_W'(irq_raw);
            ADDR_W'(OFS_RXDATA): bus_rdata = rx_empty ? '0 : DATA_W'(rx_head);
            default:             bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       cpol,
    input logic                       sclk,
    input logic                       mosi,
    input logic                       irq,
    input logic [IRQ_W-1:0]           imask,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic                       tx_full,
    input logic                       tx_take,
    input logic                       rx_under_evt,
    input logic [IRQ_W-1:0]           raw,
    input logic                       busy,
    input shift_state_t               sh_state
);
    localparam int LW = $clog2(DEPTH+1);

    assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_level == '0) && (rx_level == '0));

    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == '0) |-> !irq);

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state == ST_IDLE) |-> (sclk == cpol));

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_full && !tx_take) |=> (tx_level == LW'(DEPTH)));

    assert_underflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_under_evt |=> raw[IRQ_RXUN]);

    assert_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state != ST_IDLE) |-> busy);

    assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sh_state == ST_HALF_B) && ($past(sh_state) == ST_HALF_B)) |-> $stable(mosi));

endmodule

bind spi_fifo_master spim_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en_q),
    .cpol         (cpol_q),
    .sclk         (sclk),
    .mosi         (mosi),
    .irq          (irq),
    .imask        (imask_q),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .tx_full      (tx_full),
    .tx_take      (tx_take),
    .rx_under_evt (rx_under_evt),
    .raw          (irq_raw),
    .busy         (busy_w),
    .sh_state     (sh_state)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    import spim_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // [25] cpol, [24] cpha, [23:8] divider, [7:0] tx byte
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0000_04A1, 32'h0100_065E, 32'h0200_02C3,
        32'h0300_080F, 32'h0000_0080, 32'h0300_0701
    };

    logic        clk, rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic        sclk, mosi, miso, irq;
    logic [1:0]  cs_n;

    int total = 0;
    int bad   = 0;

    spi_fifo_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // slave model
    logic       m_cpol = 1'b0;
    logic       m_cpha = 1'b0;
    logic [7:0] sl_in = '0;
    logic [2:0] sl_bits = '0;
    int         sl_frames = 0;
    logic [7:0] cap [64];
    logic [7:0] cur_resp;

    function automatic logic [7:0] resp_fn(input int n);
        return 8'h3C + 8'(n * 29);
    endfunction

    assign cur_resp = resp_fn(sl_frames);
    assign miso     = cur_resp[~sl_bits];

    always @(sclk) begin
        if (rst_n && !cs_n[0] && sclk == ~(m_cpol ^ m_cpha)) begin
            sl_in = {sl_in[6:0], mosi};
            if (sl_bits == 3'd7) begin
                cap[sl_frames[5:0]] = sl_in;
                sl_frames = sl_frames + 1;
                sl_bits = '0;
            end else begin
                sl_bits = sl_bits + 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        rd(OFS_STATUS, s);
        while (s[0]) rd(OFS_STATUS, s);
    endtask

    task automatic measure_half(output int n);
        logic p;
        p = sclk;
        while (sclk === p) @(negedge clk);
        p = sclk; n = 0;
        while (sclk === p) begin @(negedge clk); n++; end
    endtask

    task automatic setup(input logic pol, input logic pha, input logic [15:0] dv);
        wr(OFS_CSEL, 32'h0);
        wr(OFS_CTRL, {24'h0, pol, pha, 6'h0});
        m_cpol = pol; m_cpha = pha; sl_bits = '0;
        wr(OFS_DIV, {16'h0, dv});
        wr(OFS_CSEL, 32'h1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          hp, fr, mism, exp_half;
        logic [15:0] ev;
        bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        rd(OFS_STATUS, r); chk("R1 status", r, 32'h0C);
        rd(OFS_TXLVL, r);  chk("R1 txlvl", r, 0);
        rd(OFS_RXLVL, r);  chk("R1 rxlvl", r, 0);
        rd(OFS_IRAW, r);   chk("R1 raw", r, 32'h01);
        chk("R1 cs_n", {30'h0, cs_n}, 32'h3);
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 sclk", {31'h0, sclk}, 0);

        wr(OFS_ENABLE, 32'h1);

        // vector table: one frame per mode/divider
        for (int i = 0; i < NVEC; i++) begin
            setup(VEC[i][25], VEC[i][24], VEC[i][23:8]);
            fr = sl_frames;
            wr(OFS_TXDATA, {24'h0, VEC[i][7:0]});
            measure_half(hp);
            ev = {VEC[i][23:9], 1'b0};
            exp_half = (ev < 2) ? 1 : int'(ev) / 2;
            chk("R4 half period", hp, exp_half);
            wait_idle();
            chk("R2 mosi byte", {24'h0, cap[fr[5:0]]}, {24'h0, VEC[i][7:0]});
            rd(OFS_RXDATA, r);
            chk("R3 miso byte", r, {24'h0, resp_fn(fr)});
            chk("R3 idle level", {31'h0, sclk}, {31'h0, VEC[i][25]});
            chk("R5 cs0 held", {30'h0, cs_n}, 32'h2);
        end

        // R5 select lines
        wr(OFS_CSEL, 32'h2); chk("R5 cs1", {30'h0, cs_n}, 32'h1);
        wr(OFS_CSEL, 32'h0); chk("R5 release", {30'h0, cs_n}, 32'h3);

        // R11 rx threshold, R12 masking, back-to-back frames
        setup(1'b0, 1'b0, 16'd2);
        wr(OFS_RXTHR, 32'd3);
        fr = sl_frames;
        for (int k = 0; k < 3; k++) wr(OFS_TXDATA, 32'h90 + k);
        wait_idle();
        rd(OFS_IRAW, r); chk("R11 rx below thr", {31'h0, r[4]}, 0);
        wr(OFS_TXDATA, 32'h93);
        wait_idle();
        rd(OFS_IRAW, r); chk("R11 rx at thr", {31'h0, r[4]}, 1);
        rd(OFS_RXLVL, r); chk("R14 rxlvl 4", r, 4);
        wr(OFS_IMASK, 32'h10);
        rd(OFS_ISTAT, r); chk("R12 istat", r, 32'h10);
        chk("R12 irq high", {31'h0, irq}, 1);
        wr(OFS_IMASK, 32'h0);
        chk("R12 irq low", {31'h0, irq}, 0);
        mism = 0;
        for (int k = 0; k < 4; k++) begin
            rd(OFS_RXDATA, r);
            if (r[7:0] !== resp_fn(fr + k)) mism++;
            if (cap[6'(fr + k)] !== 8'(8'h90 + k)) mism++;
        end
        chk("R2 back-to-back", mism, 0);

        // R9 receive overflow
        fr = sl_frames;
        for (int k = 0; k < 33; k++) wr(OFS_TXDATA, 32'h40 + k);
        wait_idle();
        rd(OFS_RXLVL, r);  chk("R14 rxlvl 32", r, 32);
        rd(OFS_STATUS, r); chk("R13 status rx full", r, 32'h14);
        rd(OFS_IRAW, r);   chk("R9 rx overflow", {31'h0, r[3]}, 1);
        mism = 0;
        for (int k = 0; k < 32; k++) begin
            rd(OFS_RXDATA, r);
            if (r[7:0] !== resp_fn(fr + k)) mism++;
        end
        chk("R9 kept first 32", mism, 0);

        // R8 underflow, R10 selective clear
        rd(OFS_RXDATA, r); chk("R8 empty read", r, 0);
        rd(OFS_IRAW, r);   chk("R8 underflow", r, 32'h0D);
        wr(OFS_ICLR, 32'h8);
        rd(OFS_IRAW, r);   chk("R10 wrong bit", r, 32'h0D);
        wr(OFS_ICLR, 32'h2);
        rd(OFS_IRAW, r);   chk("R10 clr underflow", r, 32'h09);
        wr(OFS_ICLR, 32'h4);
        rd(OFS_IRAW, r);   chk("R10 clr rx ovf", r, 32'h01);

        // R7 transmit overflow with a slow divider
        setup(1'b0, 1'b0, 16'd200);
        for (int k = 0; k < 40; k++) wr(OFS_TXDATA, 32'h20 + k);
        rd(OFS_TXLVL, r);  chk("R7 txlvl full", r, 32);
        wr(OFS_TXTHR, 32'd31);
        rd(OFS_IRAW, r);   chk("R7 tx overflow raw", r, 32'h02);
        rd(OFS_STATUS, r); chk("R13 status tx full busy", r, 32'h0B);
        wr(OFS_ICLR, 32'h1);
        rd(OFS_IRAW, r);   chk("R10 clear all", r, 32'h00);

        // R6 disable flushes and ignores writes
        wr(OFS_CSEL, 32'h0);
        wr(OFS_ENABLE, 32'h0);
        rd(OFS_TXLVL, r);  chk("R6 tx flushed", r, 0);
        rd(OFS_STATUS, r); chk("R6 idle status", r, 32'h0C);
        wr(OFS_TXDATA, 32'h55);
        rd(OFS_TXLVL, r);  chk("R6 write ignored", r, 0);
        rd(OFS_IRAW, r);   chk("R6 no flag", r, 32'h01);
        chk("R6 sclk idle", {31'h0, sclk}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule